// File: doc/BRIEF.md
# Multi-Code Seven-Segment Display Converter

This block turns a 4-bit input word into the drive pattern for one seven-segment digit. A 3-bit code select sets how the word is read: plain binary, inverted binary, BCD, inverted BCD, reflected Gray, or excess-3. Each reading first yields a symbol value and a validity flag. Words that have no symbol under the chosen reading, and the two unused select values, blank the digit. A glyph table then maps the symbol to segments. The hex letters b and d are drawn in lower case, and A, C, E and F in upper case.

One polarity input chooses how the segments are driven. A high segment output lights a common-cathode digit, and a low output lights a common-anode digit. A build parameter adds an output register, which gives one cycle of latency. That register stores the lit pattern before polarity is applied. Reset therefore blanks the digit in whatever polarity is selected at the moment, and a change of polarity reaches the pins at once.

Top module: `multicode_seg_decoder`

## Requirements
- R1: With code_sel = 0 (plain binary) the word is weighted 8-4-2-1 with din[3] as MSB, and the digit shows hex symbol 0..F. 0000 shows 0 and 1000 shows 8.
- R2: seg is ordered {a,b,c,d,e,f,g} from bit 6 down to bit 0. The lit patterns are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B, A=77, b=1F, C=4E, d=3D, E=4F, F=47 (hex, 1 = lit). Symbol 8 lights all segments, and b lights c,d,e,f,g.
- R3: With code_sel = 1 (inverted binary) every input bit is inverted before the 8-4-2-1 weighting, so the digit shows 15 - din.
- R4: With code_sel = 2 (BCD) words 0..9 show that digit, and words 1010..1111 blank the digit.
- R5: With code_sel = 3 (inverted BCD) words 0000..0101 blank the digit, and words 0110..1111 show the inverted word (9 down to 0).
- R6: With code_sel = 4 (reflected Gray) the word is converted to binary by an XOR prefix taken from the MSB downward, and the digit shows the resulting hex symbol.
- R7: With code_sel = 5 (excess-3) words 0011..1100 show din - 3, and words 0000..0010 and 1101..1111 blank the digit.
- R8: code_sel values 6 and 7 blank the digit whatever the word is.
- R9: With active_low = 0 a lit segment drives 1. With active_low = 1 every output is inverted, so a lit segment drives 0 and a blank digit drives all ones.
- R10: With REG_OUT = 1 the segment pattern follows din and code_sel one rising clock edge later. With REG_OUT = 0 the path is purely combinational.
- R11: With REG_OUT = 1, asserting rst_n low blanks the digit in the polarity currently selected, and the digit stays blank until the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 4 | Input word to display |
| code_sel | input | 3 | Code select for how din is read (0..5 used, 6..7 blank) |
| active_low | input | 1 | Segment polarity: 0 lights on high, 1 lights on low |
| seg | output | 7 | Segment drive {a,b,c,d,e,f,g} |

## Verification
In the registered build the segment pattern for a word applied after one falling edge is due just after the next rising edge. Polarity is applied after the register, so it takes effect in the same cycle it changes. The bench drives inputs on falling edges and samples the registered instance 2 ns after the following rising edge. It samples the combinational instance 1 ns after driving. One directed check samples the registered output before that edge to show that the old pattern is still held. The checker's properties look back one cycle with $past in the registered build, and check the same cycle in the combinational build.

// File: rtl/seg_conv_pkg.sv
package seg_conv_pkg;

  localparam int WORD_W = 4;
  localparam int SEL_W  = 3;
  localparam int SEG_W  = 7;

  typedef enum logic [SEL_W-1:0] {
    CODE_BIN  = 3'd0,
    CODE_CBIN = 3'd1,
    CODE_BCD  = 3'd2,
    CODE_CBCD = 3'd3,
    CODE_GRAY = 3'd4,
    CODE_XS3  = 3'd5,
    CODE_RSV6 = 3'd6,
    CODE_RSV7 = 3'd7
  } code_e;

  typedef struct packed {
    logic              valid;
    logic [WORD_W-1:0] value;
  } symbol_t;

  localparam logic [WORD_W-1:0] DEC_MAX  = 4'd9;
  localparam logic [WORD_W-1:0] XS3_BIAS = 4'd3;

endpackage

// File: rtl/seg_code_unpack.sv
module seg_code_unpack
  import seg_conv_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0]     word_i,
  input  logic [SEL_W-1:0] code_i,
  output symbol_t          sym_o
);

  localparam logic [W-1:0] BIAS = W'(XS3_BIAS);
  localparam logic [W-1:0] XS3_TOP = W'(DEC_MAX) + BIAS;

  logic [W-1:0] inv_word;
  logic [W-1:0] gray_bin;
  logic [W-1:0] xs3_diff;

  assign inv_word = ~word_i;
  assign xs3_diff = word_i - BIAS;

  // Gray to binary: each bit is the XOR of itself and all higher Gray bits
  assign gray_bin[W-1] = word_i[W-1];
  generate
    for (genvar gi = W - 2; gi >= 0; gi--) begin : g_gray
      assign gray_bin[gi] = gray_bin[gi+1] ^ word_i[gi];
    end
  endgenerate

  always_comb begin
    sym_o = '{valid: 1'b0, value: '0};
    unique case (code_e'(code_i))
      CODE_BIN: begin
        sym_o.valid = 1'b1;
        sym_o.value = word_i;
      end
      CODE_CBIN: begin
        sym_o.valid = 1'b1;
        sym_o.value = inv_word;
      end
      CODE_BCD: begin
        sym_o.valid = (word_i <= W'(DEC_MAX));
        sym_o.value = word_i;
      end
      CODE_CBCD: begin
        sym_o.valid = (inv_word <= W'(DEC_MAX));
        sym_o.value = inv_word;
      end
      CODE_GRAY: begin
        sym_o.valid = 1'b1;
        sym_o.value = gray_bin;
      end
      CODE_XS3: begin
        sym_o.valid = (word_i >= BIAS) && (word_i <= XS3_TOP);
        sym_o.value = xs3_diff;
      end
      default: begin
        sym_o.valid = 1'b0;
        sym_o.value = '0;
      end
    endcase
  end

endmodule

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
  import seg_conv_pkg::*;
(
  input  symbol_t          sym_i,
  output logic [SEG_W-1:0] lit_o
);

  logic [SEG_W-1:0] shape;

  // bit 6 = a ... bit 0 = g, 1 = segment lit
  always_comb begin
    unique case (sym_i.value)
      4'h0: shape = 7'h7E;
      4'h1: shape = 7'h30;
      4'h2: shape = 7'h6D;
      4'h3: shape = 7'h79;
      4'h4: shape = 7'h33;
      4'h5: shape = 7'h5B;
      4'h6: shape = 7'h5F;
      4'h7: shape = 7'h70;
      4'h8: shape = 7'h7F;
      4'h9: shape = 7'h7B;
      4'hA: shape = 7'h77;
      4'hB: shape = 7'h1F;
      4'hC: shape = 7'h4E;
      4'hD: shape = 7'h3D;
      4'hE: shape = 7'h4F;
      default: shape = 7'h47;
    endcase
  end

  assign lit_o = sym_i.valid ? shape : '0;

endmodule

// File: rtl/seg_drive_stage.sv
module seg_drive_stage
  import seg_conv_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int N       = SEG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lit_i,
  input  logic         active_low_i,
  output logic [N-1:0] seg_o
);

  logic [N-1:0] lit_view;

  generate
    if (REG_OUT) begin : g_reg
      logic [N-1:0] lit_q;
      logic [N-1:0] lit_d;
      logic         load_en;

      assign load_en = 1'b1;

      always_comb begin
        lit_d = lit_q;
        if (load_en) lit_d = lit_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lit_q <= '0;
        else        lit_q <= lit_d;
      end

      assign lit_view = lit_q;
    end else begin : g_comb
      assign lit_view = lit_i;
    end
  endgenerate

  // Polarity sits after the register so a blank reset state honours it at once
  assign seg_o = lit_view ^ {N{active_low_i}};

endmodule

// File: rtl/multicode_seg_decoder.sv
module multicode_seg_decoder
  import seg_conv_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic [SEL_W-1:0]  code_sel,
  input  logic              active_low,
  output logic [SEG_W-1:0]  seg
);

  symbol_t          sym;
  logic [SEG_W-1:0] lit;

  seg_code_unpack #(.W(WORD_W)) u_unpack (
    .word_i (din),
    .code_i (code_sel),
    .sym_o  (sym)
  );

  seg_glyph_rom u_glyph (
    .sym_i (sym),
    .lit_o (lit)
  );

  seg_drive_stage #(.REG_OUT(REG_OUT), .N(SEG_W)) u_drive (
    .clk          (clk),
    .rst_n        (rst_n),
    .lit_i        (lit),
    .active_low_i (active_low),
    .seg_o        (seg)
  );

endmodule

// File: rtl/seg_decoder_checker.sv
module seg_decoder_checker
  import seg_conv_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] din,
  input logic [SEL_W-1:0]  code_sel,
  input logic              active_low,
  input logic [SEG_W-1:0]  seg
);

  logic [SEG_W-1:0] blank_pat;
  logic [SEG_W-1:0] full_pat;
  assign blank_pat = {SEG_W{active_low}};
  assign full_pat  = {SEG_W{~active_low}};

  generate
    if (REG_OUT) begin : g_reg_chk
      p_reserved_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(code_sel) >= 3'd6)) |-> (seg == blank_pat));

      p_bcd_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(code_sel) == 3'd2) && ($past(din) > 4'd9))
        |-> (seg == blank_pat));

      p_bin_eight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(code_sel) == 3'd0) && ($past(din) == 4'd8))
        |-> (seg == full_pat));

      p_xs3_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(code_sel) == 3'd5) &&
         (($past(din) < 4'd3) || ($past(din) > 4'd12))) |-> (seg == blank_pat));

      p_reset_blank_r11: assert property (@(posedge clk)
        (!rst_n) |-> (seg == blank_pat));
    end else begin : g_comb_chk
      p_reserved_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel >= 3'd6) |-> (seg == blank_pat));

      p_bcd_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_sel == 3'd2) && (din > 4'd9)) |-> (seg == blank_pat));

      p_bin_eight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_sel == 3'd0) && (din == 4'd8)) |-> (seg == full_pat));

      p_xs3_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_sel == 3'd5) && ((din < 4'd3) || (din > 4'd12)))
        |-> (seg == blank_pat));
    end
  endgenerate

endmodule

bind multicode_seg_decoder seg_decoder_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .din        (din),
  .code_sel   (code_sel),
  .active_low (active_low),
  .seg        (seg)
);

// File: tb/multicode_seg_decoder_tb.sv
`timescale 1ns/1ps
module multicode_seg_decoder_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] din;
  logic [2:0] code_sel;
  logic       active_low;
  logic [6:0] seg_reg;
  logic [6:0] seg_comb;

  int checks;
  int fails;
  bit done;

  multicode_seg_decoder #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .code_sel(code_sel),
    .active_low(active_low), .seg(seg_reg)
  );

  multicode_seg_decoder #(.REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .din(din), .code_sel(code_sel),
    .active_low(active_low), .seg(seg_comb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] shape_of(int v);
    case (v)
      0: return 7'h7E;   1: return 7'h30;   2: return 7'h6D;   3: return 7'h79;
      4: return 7'h33;   5: return 7'h5B;   6: return 7'h5F;   7: return 7'h70;
      8: return 7'h7F;   9: return 7'h7B;  10: return 7'h77;  11: return 7'h1F;
      12: return 7'h4E; 13: return 7'h3D;  14: return 7'h4F;  default: return 7'h47;
    endcase
  endfunction

  function automatic logic [6:0] model(logic [3:0] w, logic [2:0] s, logic pol);
    int v;
    int b;
    logic [6:0] lit;
    v = -1;
    case (s)
      3'd0: v = int'(w);
      3'd1: v = 15 - int'(w);
      3'd2: v = (w <= 4'd9) ? int'(w) : -1;
      3'd3: v = ((15 - int'(w)) <= 9) ? 15 - int'(w) : -1;
      3'd4: begin
        b = 0;
        v = 0;
        for (int i = 3; i >= 0; i--) begin
          b = b ^ int'(w[i]);
          v = v | (b << i);
        end
      end
      3'd5: v = (w >= 4'd3 && w <= 4'd12) ? int'(w) - 3 : -1;
      default: v = -1;
    endcase
    lit = (v < 0) ? 7'h00 : shape_of(v);
    return pol ? ~lit : lit;
  endfunction

  function automatic string tag_of(logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: din=%h sel=%0d pol=%0b actual=%h expected=%h",
               tag, din, code_sel, active_low, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Drive on falling edge, check comb at once, registered after the next rising edge
  task automatic apply(logic [3:0] w, logic [2:0] s, logic pol, string tag);
    @(negedge clk);
    din = w; code_sel = s; active_low = pol;
    #1;
    check({tag, " comb R10"}, seg_comb, model(w, s, pol));
    @(posedge clk);
    #2;
    check({tag, " reg R10"}, seg_reg, model(w, s, pol));
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [6:0] prev;
    int seed_v;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; din = 4'h8; code_sel = 3'd0; active_low = 1'b0;
    seed_v = int'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R11: reset blanks in the current polarity
    check("R11 reset blank high", seg_reg, 7'h00);
    active_low = 1'b1;
    #1;
    check("R11 reset blank low", seg_reg, 7'h7F);
    active_low = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corners
    apply(4'h0, 3'd0, 1'b0, "R1 zero");
    apply(4'h8, 3'd0, 1'b0, "R1 R2 eight");
    apply(4'hB, 3'd0, 1'b0, "R2 letter b");
    apply(4'hD, 3'd0, 1'b1, "R2 R9 letter d");
    apply(4'h0, 3'd1, 1'b0, "R3 inv zero");
    apply(4'hA, 3'd2, 1'b0, "R4 bcd 10 blank");
    apply(4'hF, 3'd2, 1'b1, "R4 R9 bcd 15 blank");
    apply(4'h5, 3'd3, 1'b0, "R5 cbcd blank");
    apply(4'h6, 3'd3, 1'b0, "R5 cbcd nine");
    apply(4'hC, 3'd4, 1'b0, "R6 gray 8");
    apply(4'h2, 3'd5, 1'b0, "R7 xs3 blank low");
    apply(4'h3, 3'd5, 1'b0, "R7 xs3 zero");
    apply(4'hD, 3'd5, 1'b0, "R7 xs3 blank high");
    apply(4'h8, 3'd6, 1'b0, "R8 sel6");
    apply(4'h8, 3'd7, 1'b1, "R8 R9 sel7");

    // R10: registered output holds the old value until the edge
    apply(4'h1, 3'd0, 1'b0, "R10 setup");
    prev = seg_reg;
    @(negedge clk);
    din = 4'h7;
    #1;
    check("R10 hold before edge", seg_reg, prev);
    @(posedge clk);
    #2;
    check("R10 update after edge", seg_reg, model(4'h7, 3'd0, 1'b0));

    // Random sweep
    for (int n = 0; n < 400; n++) begin
      logic [3:0] w;
      logic [2:0] s;
      logic       p;
      w = 4'($urandom);
      s = 3'($urandom);
      p = 1'($urandom);
      apply(w, s, p, {tag_of(s), " R9 random"});
    end

    // R11: asynchronous reset mid-run blanks immediately
    @(negedge clk);
    din = 4'h8; code_sel = 3'd0; active_low = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R11 mid reset blank", seg_reg, 7'h7F);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 blank until edge", seg_reg, 7'h7F);
    @(posedge clk);
    #2;
    check("R11 R10 first edge", seg_reg, model(4'h8, 3'd0, 1'b1));

    report();
  end

endmodule